// File: doc/BRIEF.md
# Sound Generator Register Bus Front End

This block sits between a byte-wide host bus and a sixteen-register programmable sound generator. A four-byte I/O window is decoded on address bit 1 alone into two targets: an index (select) register and a data register. The odd offsets act as shadow copies of the even ones. The block holds the register contents and clears the unused high bits of each register as it stores them. It answers reads with the chip's read-back rules. For every register write that lands in the sound range (indices 0 to 13), it emits a one-cycle pulse on a sideband port that carries the index and the stored value.

Each accepted access raises a wait-state request for one cycle. After reset, the block replays a zero write for every sound register on the sideband port, so the downstream generator starts from a known state. The host bus must stay idle during that replay.

Top module: `sndRegBus`

## Requirements
- R1: The select register holds all 8 written bits. A value such as 0x23 does not alias index 3. A data write made while the select is 16 or more changes no register, and it raises no sideband pulse.
- R2: A read at offset 0 returns 0xFF whenever the select value is 16 or more.
- R3: Only address bit 1 chooses the target. Offsets 0 and 1 write the select register, and offsets 2 and 3 write the data register.
- R4: A read at offset 1, 2 or 3 returns 0xFF. Only offset 0 returns register contents.
- R5: An access at an odd offset with the byte-size input low is ignored. It changes no state and raises no wait request.
- R6: Stored values are masked. Indices 1, 3, 5 and 13 keep bits 3:0. Indices 6, 8, 9 and 10 keep bits 4:0. All other indices keep all 8 bits.
- R7: A select write with a value below 16 loads the read-back latch with the stored (masked) content of that register.
- R8: A data write to a valid select loads the read-back latch with the unmasked byte. For example, writing 0xF5 to index 3 reads back 0xF5 until the next select write, and reselecting index 3 then reads 0x05.
- R9: A data write to index 0 to 13 produces sndWrValid high for exactly the cycle after the write, with sndWrIdx equal to the index and sndWrData equal to the masked value. Indices 14 and 15 produce no pulse.
- R10: waitReq is high in the cycle after each accepted access (any even offset, or an odd offset with byte-size high). It is low after cycles with no accepted access.
- R11: While reset is asserted, the select register, the read-back latch and all registers read as 0, except index 14, which reads 0xFF. In the 14 cycles after reset is released, sndWrValid pulses with indices 0 through 13 in order and data 0. After that, it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Bus access strobe, one cycle per access |
| accWrite | input | 1 | 1 = write, 0 = read |
| accAddr | input | 2 | Offset within the four-byte window |
| accByte | input | 1 | High when the access is byte-sized |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the offset on accAddr (combinational) |
| waitReq | output | 1 | One-cycle wait-state request after an accepted access |
| sndWrValid | output | 1 | Sideband sound-register write pulse |
| sndWrIdx | output | 4 | Sideband register index |
| sndWrData | output | 8 | Sideband masked register value |

## Verification
The assertions assume that the host issues no access during the 14-cycle zero replay after reset, because the sideband port carries only replay pulses during that window. The bench holds the bus idle across the replay and only then starts directed and random accesses. The random stimulus biases select values below 16 and sometimes uses values of 16 or more. It drives accValid for at most one cycle per access, so the one-cycle pulse checks on waitReq and sndWrValid refer to a single access.

// File: rtl/sndRegPkg.sv
package sndRegPkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic       selWr;
    logic       dataWr;
    logic       initFwd;
    logic [3:0] initIdx;
  } ctrlStrobes_t;

  // Bits a register keeps when written
  function automatic logic [7:0] keepMask(input logic [3:0] idx);
    case (idx)
      4'd1, 4'd3, 4'd5, 4'd13: keepMask = 8'h0F;
      4'd6, 4'd8, 4'd9, 4'd10: keepMask = 8'h1F;
      default:                 keepMask = 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/sndRegCtrl.sv
module sndRegCtrl
  import sndRegPkg::*;
#(
  parameter int SoundRegs = 14
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         accValid,
  input  logic         accWrite,
  input  logic [1:0]   accAddr,
  input  logic         accByte,
  output ctrlStrobes_t strobes,
  output logic         waitReq
);
  localparam int CntW = $clog2(SoundRegs + 1);
  localparam logic [CntW-1:0] CntLimit = CntW'(SoundRegs);

  logic            accept;
  logic [CntW-1:0] initCnt;

  // Odd shadow offsets count only for byte-sized accesses
  assign accept = accValid && (!accAddr[0] || accByte);

  always_comb begin
    strobes.selWr   = accept && accWrite && !accAddr[1];
    strobes.dataWr  = accept && accWrite &&  accAddr[1];
    strobes.initFwd = initCnt < CntLimit;
    strobes.initIdx = initCnt[3:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitReq <= 1'b0;
      initCnt <= '0;
    end else begin
      waitReq <= accept;
      if (initCnt < CntLimit) initCnt <= initCnt + 1'b1;
    end
  end
endmodule

// File: rtl/sndRegData.sv
module sndRegData
  import sndRegPkg::*;
#(
  parameter int RegCount  = 16,
  parameter int SoundRegs = 14,
  parameter int PortAIdx  = 14,
  parameter int DataW     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [1:0]       accAddr,
  input  logic [DataW-1:0] wrData,
  output logic [DataW-1:0] rdData,
  output logic [DataW-1:0] selQ,
  output logic             sndWrValid,
  output logic [3:0]       sndWrIdx,
  output logic [DataW-1:0] sndWrData
);
  localparam logic [DataW-1:0] SelLimit = DataW'(RegCount);
  localparam logic [3:0]       SndLimit = 4'(SoundRegs);

  logic [DataW-1:0] regFile [RegCount];
  logic [DataW-1:0] latchQ;
  logic             selValid;
  logic [3:0]       curIdx;
  logic [DataW-1:0] maskedWr;
  logic             hostWr;

  assign selValid = selQ < SelLimit;
  assign curIdx   = selQ[3:0];
  assign maskedWr = wrData & keepMask(curIdx);
  assign hostWr   = strobes.dataWr && selValid;

  for (genvar g = 0; g < RegCount; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN)
        regFile[g] <= (g == PortAIdx) ? '1 : '0;
      else if (hostWr && curIdx == 4'(g))
        regFile[g] <= maskedWr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ   <= '0;
      latchQ <= '0;
    end else if (strobes.selWr) begin
      selQ <= wrData;
      if (wrData < SelLimit) latchQ <= regFile[wrData[3:0]];
    end else if (hostWr) begin
      latchQ <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sndWrValid <= 1'b0;
      sndWrIdx   <= '0;
      sndWrData  <= '0;
    end else if (strobes.initFwd) begin
      sndWrValid <= 1'b1;
      sndWrIdx   <= strobes.initIdx;
      sndWrData  <= '0;
    end else begin
      sndWrValid <= hostWr && (curIdx < SndLimit);
      sndWrIdx   <= curIdx;
      sndWrData  <= maskedWr;
    end
  end

  assign rdData = (accAddr == 2'd0 && selValid) ? latchQ : '1;
endmodule

// File: rtl/sndRegBus.sv
module sndRegBus
  import sndRegPkg::*;
#(
  parameter int RegCount  = 16,
  parameter int SoundRegs = 14,
  parameter int PortAIdx  = 14,
  parameter int DataW     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accValid,
  input  logic             accWrite,
  input  logic [1:0]       accAddr,
  input  logic             accByte,
  input  logic [DataW-1:0] wrData,
  output logic [DataW-1:0] rdData,
  output logic             waitReq,
  output logic             sndWrValid,
  output logic [3:0]       sndWrIdx,
  output logic [DataW-1:0] sndWrData
);
  ctrlStrobes_t     strobes;
  logic [DataW-1:0] selQ;

  sndRegCtrl #(.SoundRegs(SoundRegs)) u_ctrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accAddr(accAddr), .accByte(accByte), .strobes(strobes), .waitReq(waitReq)
  );

  sndRegData #(
    .RegCount(RegCount), .SoundRegs(SoundRegs), .PortAIdx(PortAIdx), .DataW(DataW)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .accAddr(accAddr), .wrData(wrData),
    .rdData(rdData), .selQ(selQ), .sndWrValid(sndWrValid), .sndWrIdx(sndWrIdx),
    .sndWrData(sndWrData)
  );
endmodule

// File: rtl/sndRegBusChecker.sv
module sndRegBusChecker (
  input logic       clk,
  input logic       rstN,
  input logic       accValid,
  input logic [1:0] accAddr,
  input logic       accByte,
  input logic [7:0] rdData,
  input logic       waitReq,
  input logic       sndWrValid,
  input logic [3:0] sndWrIdx,
  input logic [7:0] sndWrData,
  input logic [7:0] selQ
);
  AST_WAIT_AFTER_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accAddr[0]) |=> waitReq); // R10
  AST_NO_WAIT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |=> !waitReq); // R10
  AST_NO_WAIT_ODD_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && accAddr[0] && !accByte) |=> !waitReq); // R5
  AST_SHADOW_READ_FF: assert property (@(posedge clk) disable iff (!rstN)
    (accAddr != 2'd0) |-> rdData == 8'hFF); // R4
  AST_BAD_SEL_READ_FF: assert property (@(posedge clk) disable iff (!rstN)
    (selQ >= 8'd16) |-> rdData == 8'hFF); // R2
  AST_FWD_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    sndWrValid |-> sndWrIdx < 4'd14); // R9
  AST_FWD_MASK4: assert property (@(posedge clk) disable iff (!rstN)
    (sndWrValid && (sndWrIdx == 4'd1 || sndWrIdx == 4'd3 || sndWrIdx == 4'd5 ||
     sndWrIdx == 4'd13)) |-> sndWrData[7:4] == 4'd0); // R6
  AST_FWD_MASK5: assert property (@(posedge clk) disable iff (!rstN)
    (sndWrValid && (sndWrIdx == 4'd6 || sndWrIdx == 4'd8 || sndWrIdx == 4'd9 ||
     sndWrIdx == 4'd10)) |-> sndWrData[7:5] == 3'd0); // R6
endmodule

bind sndRegBus sndRegBusChecker u_chk (
  .clk(clk), .rstN(rstN), .accValid(accValid), .accAddr(accAddr), .accByte(accByte),
  .rdData(rdData), .waitReq(waitReq), .sndWrValid(sndWrValid), .sndWrIdx(sndWrIdx),
  .sndWrData(sndWrData), .selQ(selQ)
);

// File: tb/test_sndRegBus.sv
`timescale 1ns/1ps
module test_sndRegBus;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       accValid = 1'b0, accWrite = 1'b0, accByte = 1'b1;
  logic [1:0] accAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData, sndWrData;
  logic       waitReq, sndWrValid;
  logic [3:0] sndWrIdx;

  int compared = 0, mismatched = 0;
  logic [7:0] mRegs [16];
  logic [7:0] mSel, mLatch, lastRd;

  always #2 clk = ~clk;

  sndRegBus i_sndRegBus (.*);

  function automatic logic [7:0] benchMask(input int idx);
    if (idx == 1 || idx == 3 || idx == 5 || idx == 13) return 8'h0F;
    if (idx == 6 || idx == 8 || idx == 9 || idx == 10) return 8'h1F;
    return 8'hFF;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // One bus access, checked against the bench model
  task automatic access(input bit wr, input logic [1:0] addr, input bit byteSz,
                        input logic [7:0] data, input string req);
    bit accept = !addr[0] || byteSz;
    logic [7:0] expRd = (addr == 2'd0 && mSel < 8'd16) ? mLatch : 8'hFF;
    bit expV = 1'b0;
    logic [3:0] expIdx = mSel[3:0];
    logic [7:0] expData = data & benchMask(int'(mSel[3:0]));
    accValid = 1'b1; accWrite = wr; accAddr = addr; accByte = byteSz; wrData = data;
    #1;
    lastRd = rdData;
    if (!wr) chk(rdData == expRd, req, rdData, expRd);
    if (accept && wr) begin
      if (!addr[1]) begin
        mSel = data;
        if (data < 8'd16) mLatch = mRegs[data[3:0]];
      end else if (mSel < 8'd16) begin
        mRegs[mSel[3:0]] = expData;
        mLatch = data;
        expV = mSel < 8'd14;
      end
    end
    @(posedge clk); #1;
    chk(waitReq == accept, {req, "/R10 wait"}, waitReq, accept);
    chk(sndWrValid == expV, {req, "/R9 fwd"}, sndWrValid, expV);
    if (expV) begin
      chk(sndWrIdx == expIdx, {req, "/R9 idx"}, sndWrIdx, expIdx);
      chk(sndWrData == expData, {req, "/R6 data"}, sndWrData, expData);
    end
    accValid = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 16; i++) mRegs[i] = (i == 14) ? 8'hFF : 8'h00;
    mSel = 8'h00; mLatch = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    chk(rdData == 8'h00, "R11 reset latch", rdData, 0);
    chk(sndWrValid == 1'b0 && waitReq == 1'b0, "R11 reset outs", sndWrValid, 0);
    @(negedge clk); rstN = 1'b1;
    for (int k = 0; k < 14; k++) begin
      @(posedge clk); #1;
      chk(sndWrValid && sndWrIdx == 4'(k) && sndWrData == 8'h00, "R11 replay",
          {sndWrValid, sndWrIdx, sndWrData}, {1'b1, 4'(k), 8'h00});
    end
    @(posedge clk); #1;
    chk(sndWrValid == 1'b0, "R11 replay end", sndWrValid, 0);

    access(1, 2'd0, 1, 8'd14, "R11 sel14");
    access(0, 2'd0, 1, 8'd0, "R11 rd14");
    chk(lastRd == 8'hFF, "R11 port reg", lastRd, 8'hFF);
    // R8 / R7 / R6
    access(1, 2'd0, 1, 8'd3, "R7 sel3");
    access(1, 2'd2, 1, 8'hF5, "R8 wr3");
    access(0, 2'd0, 1, 8'd0, "R8 rd3");
    chk(lastRd == 8'hF5, "R8 unmasked", lastRd, 8'hF5);
    access(1, 2'd0, 1, 8'd3, "R7 resel3");
    access(0, 2'd0, 1, 8'd0, "R7 rd3");
    chk(lastRd == 8'h05, "R7 masked", lastRd, 8'h05);
    // R1 / R2
    access(1, 2'd0, 1, 8'h23, "R1 sel23");
    access(0, 2'd0, 1, 8'd0, "R2 rd23");
    chk(lastRd == 8'hFF, "R2 bad sel", lastRd, 8'hFF);
    access(1, 2'd2, 1, 8'hAA, "R1 wr bad sel");
    access(1, 2'd0, 1, 8'd3, "R1 resel3");
    access(0, 2'd0, 1, 8'd0, "R1 rd3");
    chk(lastRd == 8'h05, "R1 discard", lastRd, 8'h05);
    // R3 / R5 shadow offsets
    access(1, 2'd1, 1, 8'd8, "R3 sel odd");
    access(1, 2'd3, 1, 8'hFF, "R3 wr odd");
    access(1, 2'd3, 0, 8'h07, "R5 wide wr");
    access(1, 2'd1, 0, 8'd2, "R5 wide sel");
    access(1, 2'd0, 1, 8'd8, "R6 resel8");
    access(0, 2'd0, 1, 8'd0, "R6 rd8");
    chk(lastRd == 8'h1F, "R6 mask5", lastRd, 8'h1F);
    // R4
    access(0, 2'd1, 1, 8'd0, "R4 rd1");
    chk(lastRd == 8'hFF, "R4 off1", lastRd, 8'hFF);
    access(0, 2'd2, 1, 8'd0, "R4 rd2");
    access(0, 2'd3, 0, 8'd0, "R4 rd3");
    // R9: index 15 not forwarded
    access(1, 2'd0, 1, 8'd15, "R9 sel15");
    access(1, 2'd2, 1, 8'hC3, "R9 wr15");
    access(1, 2'd0, 1, 8'd15, "R9 resel15");
    access(0, 2'd0, 1, 8'd0, "R9 rd15");
    chk(lastRd == 8'hC3, "R9 full byte", lastRd, 8'hC3);
    // idle cycle, no wait
    @(posedge clk); #1;
    chk(waitReq == 1'b0, "R10 idle", waitReq, 0);

    for (int n = 0; n < 400; n++) begin
      logic [1:0] a = 2'($urandom % 4);
      bit w = 1'($urandom % 2);
      bit b = ($urandom % 4) != 0;
      logic [7:0] d = 8'($urandom);
      if (w && !a[1] && ($urandom % 8) != 0) d = d & 8'h0F;
      access(w, a, b, d, "R3 random");
    end
    summary();
  end
endmodule